// File: doc/BRIEF.md
# Configuration Sequencing Controller

This block is the finite state machine that walks a programmable device from power-up into user operation. It holds off until both the core and the I/O supply report good. It then clears configuration memory for a fixed number of cycles while it pulls a shared open-drain status line low. Once clearing ends it lets the line go. Either an external agent holding the line low or a low on the reload request input keeps the device in the clearing phase. The mode pins are captured when the controller first sees the line high.

With the line high, the controller accepts 32-bit configuration words and folds each one into a running 16-bit CRC. When the loader signals end of loading, the CRC of every word except the last is compared with the low half of the last word. A match starts a three-step start-up: DONE rises, then the user I/Os are enabled, then the global set/reset net is released. A mismatch aborts: the status line is pulled low again as an error flag. Only a low on the reload request or a loss of supply leads out of that state.

The reload request and the sensed line level each pass through a two-flop synchroniser. The surrounding system models the open-drain line: the sensed level is low whenever this block or any other agent pulls it down.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: While `rst` is high, or while either supply-good input is low, `stat_pull_low` is 1 and `done_out`, `io_enable` and `gsr_release` are 0. Clearing does not begin until both supplies are good; a supply loss at any time returns the block to this state by the next cycle.
- R2: After both supplies become good, `stat_pull_low` stays at 1 for at least `CLR_CYCLES` clock cycles before it is released.
- R3: While `prog_n` is held low, `stat_pull_low` stays at 1 and the clearing count restarts, so the line is released no earlier than `CLR_CYCLES` cycles after `prog_n` returns high.
- R4: If the sensed line stays low after the block releases it, the block stays in the clearing phase with `done_out` at 0. `mode_latched` takes the value of `mode_pins` on the cycle the synchronised line is first seen high.
- R5: Words offered on `frame_data` with `frame_valid` are ignored unless loading is in progress. Loading begins only after the synchronised line is seen high. A word presented in the same cycle as `load_end` is also dropped.
- R6: The CRC uses polynomial x^16+x^15+x^2+1 (0x8005), starts from 0 and takes each word's bits from bit 31 down to bit 0. It covers every accepted word except the last one. The expected value is bits 15:0 of the last accepted word.
- R7: On a CRC match, `done_out` is 1 in the cycle after `load_end` is sampled, `io_enable` rises one cycle later, and `gsr_release` rises one cycle after that.
- R8: On a CRC mismatch, `stat_pull_low` is 1 and `done_out` is 0 from the cycle after `load_end` is sampled. The block stays there until `prog_n` goes low.
- R9: A low on `prog_n` in any state after power-up drives `done_out`, `io_enable` and `gsr_release` to 0 and `stat_pull_low` to 1 within four cycles. The full sequence then restarts from clearing.
- R10: `mode_latched` holds its value except at a capture event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_pwr_ok | input | 1 | Core supply good |
| io_pwr_ok | input | 1 | I/O supply good |
| prog_n | input | 1 | Active-low reload request (asynchronous) |
| stat_line_in | input | 1 | Sensed level of the shared open-drain status line (asynchronous) |
| mode_pins | input | MODE_W | Mode selection pins |
| frame_data | input | 32 | Configuration word |
| frame_valid | input | 1 | Word strobe for `frame_data` |
| load_end | input | 1 | Loader has delivered the final word |
| stat_pull_low | output | 1 | Pull-down enable for the status line |
| done_out | output | 1 | Configuration done |
| io_enable | output | 1 | User I/O enable |
| gsr_release | output | 1 | Global set/reset release |
| mode_latched | output | MODE_W | Mode value captured at line release |

## Verification
A wrong internal state shows at the ports quickly. A state entered early or late moves the release of the status line, and the bench counts that to the cycle. A skipped or reordered start-up step changes the exact cycle in which DONE, I/O enable or reset release rise after end of loading. A CRC register that took a stray word, or missed one, turns a good load into an abort. That abort shows as the line pulled low one cycle after end of loading, and it stays low until the next reload.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int WORD_W   = 32;
    localparam int CRC_W    = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;

    typedef enum logic [2:0] {
        ST_PWR_WAIT,
        ST_CLEAR,
        ST_RELEASE,
        ST_LOAD,
        ST_RISE_DONE,
        ST_RISE_IO,
        ST_USER,
        ST_ABORT
    } seq_state_e;

    typedef struct packed {
        logic pull_low;
        logic done;
        logic io_en;
        logic gsr_rel;
    } seq_out_t;

    // Fold one word into the CRC, most significant bit first.
    function automatic logic [CRC_W-1:0] crc_fold_word(
        input logic [CRC_W-1:0]  crc_in,
        input logic [WORD_W-1:0] word
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ word[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction

    function automatic seq_out_t state_outputs(input seq_state_e s);
        seq_out_t o;
        o = '0;
        case (s)
            ST_PWR_WAIT, ST_CLEAR, ST_ABORT: o.pull_low = 1'b1;
            ST_RISE_DONE: o.done = 1'b1;
            ST_RISE_IO: begin
                o.done  = 1'b1;
                o.io_en = 1'b1;
            end
            ST_USER: begin
                o.done    = 1'b1;
                o.io_en   = 1'b1;
                o.gsr_rel = 1'b1;
            end
            default: o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/cfg_sync_chain.sv
module cfg_sync_chain #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_clear_timer.sv
module cfg_clear_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    assign expired = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cfg_crc_acc.sv
module cfg_crc_acc
    import cfg_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    output logic              match
);
    logic [CRC_W-1:0]  crc_run;
    logic [CRC_W-1:0]  crc_before_last;
    logic [WORD_W-1:0] last_word;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_run         <= '0;
            crc_before_last <= '0;
            last_word       <= '0;
        end else if (word_vld) begin
            crc_before_last <= crc_run;
            crc_run         <= crc_fold_word(crc_run, word);
            last_word       <= word;
        end
    end

    assign match = (crc_before_last == last_word[CRC_W-1:0]);
endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
    import cfg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_ok,
    input  logic       prog_ok,
    input  logic       line_high,
    input  logic       clr_done,
    input  logic       load_end,
    input  logic       crc_match,
    output seq_state_e state
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        if (!pwr_ok) begin
            nxt = ST_PWR_WAIT;
        end else if (state == ST_PWR_WAIT) begin
            nxt = ST_CLEAR;
        end else if (!prog_ok) begin
            nxt = ST_CLEAR;
        end else begin
            case (state)
                ST_CLEAR:     if (clr_done)  nxt = ST_RELEASE;
                ST_RELEASE:   if (line_high) nxt = ST_LOAD;
                ST_LOAD:      if (load_end)  nxt = crc_match ? ST_RISE_DONE : ST_ABORT;
                ST_RISE_DONE: nxt = ST_RISE_IO;
                ST_RISE_IO:   nxt = ST_USER;
                default:      nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_PWR_WAIT;
        else     state <= nxt;
    end
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
    import cfg_seq_pkg::*;
#(
    parameter int CLR_CYCLES  = 16,
    parameter int MODE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_pwr_ok,
    input  logic              io_pwr_ok,
    input  logic              prog_n,
    input  logic              stat_line_in,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic [31:0]       frame_data,
    input  logic              frame_valid,
    input  logic              load_end,
    output logic              stat_pull_low,
    output logic              done_out,
    output logic              io_enable,
    output logic              gsr_release,
    output logic [MODE_W-1:0] mode_latched
);
    logic       prog_s;
    logic       line_s;
    logic       clr_done;
    logic       crc_match;
    logic       word_take;
    seq_state_e state;
    seq_out_t   outs;

    cfg_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_prog_sync (
        .clk(clk), .rst(rst), .d(prog_n), .q(prog_s)
    );

    cfg_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_line_sync (
        .clk(clk), .rst(rst), .d(stat_line_in), .q(line_s)
    );

    cfg_clear_timer #(.CYCLES(CLR_CYCLES)) u_timer (
        .clk(clk), .rst(rst),
        .run((state == ST_CLEAR) && prog_s),
        .expired(clr_done)
    );

    assign word_take = frame_valid && !load_end && (state == ST_LOAD);

    cfg_crc_acc u_crc (
        .clk(clk), .rst(rst),
        .clr(state != ST_LOAD),
        .word_vld(word_take),
        .word(frame_data),
        .match(crc_match)
    );

    cfg_seq_fsm u_fsm (
        .clk(clk), .rst(rst),
        .pwr_ok(core_pwr_ok && io_pwr_ok),
        .prog_ok(prog_s),
        .line_high(line_s),
        .clr_done(clr_done),
        .load_end(load_end),
        .crc_match(crc_match),
        .state(state)
    );

    always_ff @(posedge clk) begin
        if (rst) mode_latched <= '0;
        else if (state == ST_RELEASE && line_s && prog_s && core_pwr_ok && io_pwr_ok)
            mode_latched <= mode_pins;
    end

    assign outs          = state_outputs(state);
    assign stat_pull_low = outs.pull_low;
    assign done_out      = outs.done;
    assign io_enable     = outs.io_en;
    assign gsr_release   = outs.gsr_rel;
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk #(
    parameter int MODE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              core_pwr_ok,
    input logic              io_pwr_ok,
    input logic              stat_pull_low,
    input logic              done_out,
    input logic              io_enable,
    input logic              gsr_release,
    input logic [MODE_W-1:0] mode_latched
);
    // R1
    supply_loss_chk: assert property (@(posedge clk) disable iff (rst)
        !(core_pwr_ok && io_pwr_ok) |=> (stat_pull_low && !done_out && !io_enable && !gsr_release));

    // R8
    pull_excludes_done_chk: assert property (@(posedge clk) disable iff (rst)
        stat_pull_low |-> !done_out);

    // R7
    io_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(io_enable) |-> $past(done_out));

    // R7
    gsr_after_io_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gsr_release) |-> ($past(io_enable) && io_enable && done_out));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_latched) |-> !$past(stat_pull_low));
endmodule

bind cfg_seq_ctrl cfg_seq_chk #(.MODE_W(MODE_W)) u_chk (
    .clk(clk), .rst(rst),
    .core_pwr_ok(core_pwr_ok), .io_pwr_ok(io_pwr_ok),
    .stat_pull_low(stat_pull_low), .done_out(done_out),
    .io_enable(io_enable), .gsr_release(gsr_release),
    .mode_latched(mode_latched)
);

// File: tb/cfg_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfg_seq_ctrl_tb_top;
    localparam int N  = 16;
    localparam int MW = 3;
    localparam int WATCHDOG_CYCLES = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          core_pwr_ok = 1'b0;
    logic          io_pwr_ok = 1'b0;
    logic          prog_n = 1'b1;
    logic          ext_hold = 1'b0;
    logic          stat_line_in;
    logic [MW-1:0] mode_pins = '0;
    logic [31:0]   frame_data = '0;
    logic          frame_valid = 1'b0;
    logic          load_end = 1'b0;
    logic          stat_pull_low, done_out, io_enable, gsr_release;
    logic [MW-1:0] mode_latched;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    assign stat_line_in = !(stat_pull_low || ext_hold);

    cfg_seq_ctrl #(.CLR_CYCLES(N), .MODE_W(MW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst),
        .core_pwr_ok(core_pwr_ok), .io_pwr_ok(io_pwr_ok),
        .prog_n(prog_n), .stat_line_in(stat_line_in),
        .mode_pins(mode_pins), .frame_data(frame_data),
        .frame_valid(frame_valid), .load_end(load_end),
        .stat_pull_low(stat_pull_low), .done_out(done_out),
        .io_enable(io_enable), .gsr_release(gsr_release),
        .mode_latched(mode_latched)
    );

    function automatic logic [15:0] ref_crc_word(input logic [15:0] c, input logic [31:0] w);
        logic [15:0] r;
        r = c;
        for (int b = 31; b >= 0; b--) begin
            if (r[15] != w[b]) r = (r << 1) ^ 16'h8005;
            else               r = r << 1;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Wait for the line release; returns the number of cycles the pull was held.
    task automatic wait_release(output int held);
        held = 0;
        while (stat_pull_low && held < 2000) begin
            @(negedge clk);
            if (stat_pull_low) held++;
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        frame_data  = w;
        frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
        frame_data  = $urandom;
        tick(int'($urandom_range(0, 2)));
    endtask

    // Send n words whose last carries the CRC of the others; optionally corrupt it.
    task automatic send_load(input int n, input bit corrupt);
        logic [15:0] c;
        logic [31:0] w;
        c = '0;
        for (int i = 0; i < n - 1; i++) begin
            w = $urandom;
            c = ref_crc_word(c, w);
            send_word(w);
        end
        w = {16'($urandom), c ^ (corrupt ? 16'h0100 : 16'h0000)};
        send_word(w);
        load_end = 1'b1;
        @(negedge clk);
        load_end = 1'b0;
    endtask

    task automatic expect_startup(input string tag);
        check(done_out && !io_enable && !gsr_release, {tag, " R7 step1"}, {done_out, io_enable, gsr_release}, 3'b100);
        @(negedge clk);
        check(done_out && io_enable && !gsr_release, {tag, " R7 step2"}, {done_out, io_enable, gsr_release}, 3'b110);
        @(negedge clk);
        check(done_out && io_enable && gsr_release && !stat_pull_low, {tag, " R7 step3"},
              {done_out, io_enable, gsr_release}, 3'b111);
    endtask

    task automatic reload(output int held);
        prog_n = 1'b0;
        tick(4);
        check(stat_pull_low && !done_out && !io_enable && !gsr_release, "R9 reload",
              {stat_pull_low, done_out, io_enable, gsr_release}, 4'b1000);
        prog_n = 1'b1;
        wait_release(held);
        tick(6);
    endtask

    initial begin
        int held;
        bit ok;
        void'($urandom(32'd20240611));

        // R1: reset state
        tick(3);
        check(stat_pull_low && !done_out && !io_enable && !gsr_release, "R1 reset",
              {stat_pull_low, done_out, io_enable, gsr_release}, 4'b1000);
        rst = 1'b0;

        // R1 with only the core supply: clearing must not complete; R5 frames ignored
        core_pwr_ok = 1'b1;
        ok = 1;
        for (int i = 0; i < 3 * N; i++) begin
            if (i == 5) send_word(32'hDEAD_BEEF);
            @(negedge clk);
            if (!stat_pull_low || done_out) ok = 0;
        end
        check(ok, "R1 one supply", int'(ok), 1);

        // R2: clearing duration with mode pins
        mode_pins = 3'd5;
        io_pwr_ok = 1'b1;
        wait_release(held);
        check(held >= N && held <= N + 2, "R2 clear length", held, N);
        tick(6);
        check(mode_latched == 3'd5, "R4 mode capture", mode_latched, 5);

        // R6/R7: good load
        send_load(4, 1'b0);
        expect_startup("first");
        mode_pins = 3'd2;
        tick(3);
        check(mode_latched == 3'd5, "R10 mode hold", mode_latched, 5);

        // R9: reload from user operation, R3 long hold
        prog_n = 1'b0;
        tick(4);
        check(stat_pull_low && !done_out && !io_enable && !gsr_release, "R9 from user",
              {stat_pull_low, done_out, io_enable, gsr_release}, 4'b1000);
        ok = 1;
        for (int i = 0; i < 3 * N; i++) begin
            @(negedge clk);
            if (!stat_pull_low) ok = 0;
        end
        check(ok, "R3 prog hold", int'(ok), 1);
        ext_hold = 1'b1;
        prog_n = 1'b1;
        wait_release(held);
        check(held >= N && held <= N + 4, "R3 clear after prog", held, N);

        // R4/R5: external hold keeps clearing; frames during it are ignored
        ok = 1;
        for (int i = 0; i < 2 * N; i++) begin
            mode_pins = 3'($urandom);
            if (i == 7) send_word(32'h1234_5678);
            @(negedge clk);
            if (done_out) ok = 0;
        end
        check(ok, "R4 external hold", int'(ok), 1);
        check(mode_latched == 3'd5, "R10 no capture while held", mode_latched, 5);
        mode_pins = 3'd6;
        ext_hold = 1'b0;
        tick(6);
        check(mode_latched == 3'd6, "R4 capture after hold", mode_latched, 6);
        send_load(3, 1'b0);
        expect_startup("after hold");

        // R8: mismatch
        reload(held);
        send_load(3, 1'b1);
        check(stat_pull_low && !done_out, "R8 abort", {stat_pull_low, done_out}, 2'b10);
        tick(10);
        check(stat_pull_low && !done_out && !io_enable, "R8 abort held",
              {stat_pull_low, done_out, io_enable}, 3'b100);

        // R5: word together with load_end dropped
        reload(held);
        begin
            logic [15:0] c;
            logic [31:0] w;
            w = $urandom;
            c = ref_crc_word(16'h0, w);
            send_word(w);
            send_word({16'h0, c});
            frame_data  = 32'hFFFF_0000;
            frame_valid = 1'b1;
            load_end    = 1'b1;
            @(negedge clk);
            frame_valid = 1'b0;
            load_end    = 1'b0;
        end
        expect_startup("R5 drop with end");

        // Random trials: R6, R7, R8, R9
        for (int t = 0; t < 24; t++) begin
            bit bad;
            int n;
            bad = ($urandom_range(0, 2) == 0);
            n = int'($urandom_range(2, 7));
            reload(held);
            send_load(n, bad);
            if (bad)
                check(stat_pull_low && !done_out, "R8 random mismatch", {stat_pull_low, done_out}, 2'b10);
            else
                expect_startup("R6 random match");
        end

        // R1: supply loss during user operation
        reload(held);
        send_load(2, 1'b0);
        tick(3);
        io_pwr_ok = 1'b0;
        @(negedge clk);
        check(stat_pull_low && !done_out && !io_enable && !gsr_release, "R1 supply loss",
              {stat_pull_low, done_out, io_enable, gsr_release}, 4'b1000);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule